// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the instruction fetch stream and flags every fetched half-word whose address satisfies one of a small set of programmable breakpoint comparators. Each comparator can match one address exactly, match under a bit mask, or match inside or outside an address window. A match can be restricted to user or supervisor privilege and to one value of the instruction-space bit. The number of low address bits that take part in the compare depends on the page's instruction encoding. Pages with mixed 16/32-bit encoding drop only bit 0. Fixed 32-bit pages, and any fetch that missed the translation buffer, drop bits 1:0.

The per-half-word hit flags travel down the pipeline with the instruction bytes. At the instruction boundary the pipeline presents them to a small state machine, one half-word per beat. The state machine has two states. `BND_FIRST` expects the opening half-word of an instruction. `BND_SECOND` expects the tail half-word of a 32-bit instruction. It has three transitions:
- `BND_FIRST -> BND_SECOND` on an unblocked opening half-word that starts a 32-bit instruction.
- `BND_SECOND -> BND_FIRST` on the tail half-word.
- any state `-> BND_FIRST` on a flush.

Only an opening half-word can raise a debug event. The event is recorded in a sticky status bit whether or not debug exceptions are enabled. A one-cycle exception request is raised only while the global enable is set.

Top module: `iac_unit`

## Requirements
- R1: On a fetch with `fetch_vle`=1 and `fetch_tlb_hit`=1, address bit 0 is ignored and bits ADDR_W-1:1 are compared.
- R2: On a fetch with `fetch_vle`=0, address bits 1:0 are ignored and bits ADDR_W-1:2 are compared.
- R3: On a fetch with `fetch_tlb_hit`=0, bits 1:0 are ignored regardless of `fetch_vle`.
- R4: One clock after a fetch beat, `hw_tag[i]` is the OR over all comparators of a hit for the half-word at the fetch base plus 2*i, and `tag_valid` is the registered `fetch_valid`. The fetch base is `fetch_addr` with bits log2(2*FETCH_HW)-1:0 cleared. Tags are zero when `tag_valid` is 0.
- R5: Mode 1 (masked) matches when (addr & B) == (A & B).
- R6: Mode 2 (range) matches when A <= addr < B if control bit 3 is 0. It matches when the address is outside that window if bit 3 is 1.
- R7: Control bits 5:4 qualify privilege and bits 7:6 qualify instruction space. Value 2'b1x requires `fetch_pr` (or `fetch_is`) to equal bit 4 (or bit 6); 2'b0x accepts either value.
- R8: An event fires only on a valid half-word in `BND_FIRST` with `bnd_tag`=1. A tail half-word in `BND_SECOND` never fires. `bnd_flush` returns the machine to `BND_FIRST` and discards that beat.
- R9: A beat with `bnd_blocked`=1 in `BND_FIRST` fires no event and leaves the state unchanged.
- R10: `evt_status` is set by an event even when the global enable is 0. It stays set until a configuration write to address {NUM_CMP,2'b01} with data bit 0 = 1, and a write with bit 0 = 0 leaves it set.
- R11: `dbg_req` pulses for one cycle, together with the status update, for each event, and only when the global enable (address {NUM_CMP,2'b00}, bit 0) is 1.
- R12: After reset no comparator is enabled, and all tags, `evt_status` and `dbg_req` are 0. A comparator with control bit 0 = 0, or with mode 3, never matches.
- R13: Configuration address {slot, sel}: sel 0 is control, sel 1 is value A, sel 2 is value B. Control bit 0 is enable, bits 2:1 are mode (0 exact on A). A write takes effect for fetches on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register address {slot, sel} |
| cfg_wdata | input | ADDR_W | Configuration write data |
| fetch_valid | input | 1 | Fetch beat present |
| fetch_addr | input | ADDR_W | Fetch group byte address |
| fetch_vle | input | 1 | Page uses mixed 16/32-bit encoding |
| fetch_tlb_hit | input | 1 | Fetch translation hit |
| fetch_pr | input | 1 | 1 = user mode, 0 = supervisor |
| fetch_is | input | 1 | Instruction-space bit |
| hw_tag | output | FETCH_HW | Per-half-word hit flags |
| tag_valid | output | 1 | hw_tag belongs to a fetch beat |
| bnd_valid | input | 1 | Half-word presented at the instruction boundary |
| bnd_tag | input | 1 | Hit flag carried by that half-word |
| bnd_long | input | 1 | The instruction opened by this half-word is 32-bit |
| bnd_blocked | input | 1 | Higher-priority exception prevents the instruction from starting |
| bnd_flush | input | 1 | Pipeline redirect, restart instruction alignment |
| evt_status | output | 1 | Sticky breakpoint event status |
| dbg_req | output | 1 | One-cycle debug exception request |

## Verification
The bench probes the compare-width boundary by placing a comparator on the upper half-word of a word. A design that dropped too many bits on a mixed-encoding page would tag both half-words. One that ignored the translation miss would tag only one. The range window is tested at its lower bound, its exclusive upper bound and with the outside sense, where an off-by-one comparison flips exactly one of those results. At the boundary, a hit flag on the tail of a 32-bit instruction, on a blocked beat, and after a flush mid-instruction separates a machine that tracks alignment correctly from one that fires on any tagged half-word or that loses its place. The status tests cover recording with the enable off, clearing with a zero data bit, and the length of the request pulse. These catch a status that follows the enable, a clear that ignores its data, or a request that is held as a level.

// File: rtl/iac_pkg.sv
package iac_pkg;

    typedef enum logic [1:0] {
        MODE_EXACT = 2'd0,
        MODE_MASK  = 2'd1,
        MODE_RANGE = 2'd2,
        MODE_OFF   = 2'd3
    } iac_mode_e;

    // Control word layout, LSB first: en, mode, outside, priv qual, space qual
    typedef struct packed {
        logic [1:0] is_q;
        logic [1:0] pr_q;
        logic       outside;
        iac_mode_e  mode;
        logic       en;
    } iac_ctrl_t;

    typedef enum logic {
        BND_FIRST  = 1'b0,
        BND_SECOND = 1'b1
    } bnd_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_VAL_A = 2'd1;
    localparam logic [1:0] SEL_VAL_B = 2'd2;
    localparam logic [1:0] SEL_G_EN  = 2'd0;
    localparam logic [1:0] SEL_G_CLR = 2'd1;

endpackage

// File: rtl/iac_cfg_regs.sv
module iac_cfg_regs
    import iac_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_CMP = 2,
    parameter int CFG_AW  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output iac_ctrl_t [NUM_CMP-1:0]           ctrl,
    output logic [NUM_CMP-1:0][ADDR_W-1:0]    val_a,
    output logic [NUM_CMP-1:0][ADDR_W-1:0]    val_b,
    output logic                              glob_en,
    output logic                              clr_req
);

    localparam int SLOT_W = CFG_AW - 2;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        sel;
    logic              glob_en_q;

    assign slot = cfg_addr[CFG_AW-1:2];
    assign sel  = cfg_addr[1:0];

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_slot
        iac_ctrl_t         ctrl_q;
        logic [ADDR_W-1:0] a_q;
        logic [ADDR_W-1:0] b_q;
        logic              hit_slot;

        assign hit_slot = cfg_we && (slot == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q <= '0;
                a_q    <= '0;
                b_q    <= '0;
            end else if (hit_slot) begin
                case (sel)
                    SEL_CTRL:  ctrl_q <= iac_ctrl_t'(cfg_wdata[7:0]);
                    SEL_VAL_A: a_q    <= cfg_wdata;
                    SEL_VAL_B: b_q    <= cfg_wdata;
                    default:   ;
                endcase
            end
        end

        assign ctrl[g]  = ctrl_q;
        assign val_a[g] = a_q;
        assign val_b[g] = b_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en_q <= 1'b0;
        end else if (cfg_we && slot == SLOT_W'(NUM_CMP) && sel == SEL_G_EN) begin
            glob_en_q <= cfg_wdata[0];
        end
    end

    assign glob_en = glob_en_q;
    assign clr_req = cfg_we && (slot == SLOT_W'(NUM_CMP)) && (sel == SEL_G_CLR) && cfg_wdata[0];

endmodule

// File: rtl/iac_match.sv
module iac_match
    import iac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              vle_page,
    input  logic              pr,
    input  logic              is_bit,
    input  iac_ctrl_t         ctrl,
    input  logic [ADDR_W-1:0] val_a,
    input  logic [ADDR_W-1:0] val_b,
    output logic              hit
);

    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] a_t;
    logic [ADDR_W-1:0] lo_t;
    logic [ADDR_W-1:0] hi_t;
    logic              raw;
    logic              in_win;
    logic              pr_ok;
    logic              is_ok;

    always_comb begin
        keep   = vle_page ? ~ADDR_W'(1) : ~ADDR_W'(3);
        a_t    = addr  & keep;
        lo_t   = val_a & keep;
        hi_t   = val_b & keep;
        in_win = (a_t >= lo_t) && (a_t < hi_t);
        unique case (ctrl.mode)
            MODE_EXACT: raw = (a_t == lo_t);
            MODE_MASK:  raw = ((a_t & hi_t) == (lo_t & hi_t));
            MODE_RANGE: raw = in_win ^ ctrl.outside;
            MODE_OFF:   raw = 1'b0;
        endcase
        pr_ok = !ctrl.pr_q[1] || (pr == ctrl.pr_q[0]);
        is_ok = !ctrl.is_q[1] || (is_bit == ctrl.is_q[0]);
        hit   = ctrl.en && raw && pr_ok && is_ok;
    end

endmodule

// File: rtl/iac_tagger.sv
module iac_tagger
    import iac_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_CMP  = 2,
    parameter int FETCH_HW = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fetch_valid,
    input  logic [ADDR_W-1:0]              fetch_addr,
    input  logic                           fetch_vle,
    input  logic                           fetch_tlb_hit,
    input  logic                           fetch_pr,
    input  logic                           fetch_is,
    input  iac_ctrl_t [NUM_CMP-1:0]        ctrl,
    input  logic [NUM_CMP-1:0][ADDR_W-1:0] val_a,
    input  logic [NUM_CMP-1:0][ADDR_W-1:0] val_b,
    output logic [FETCH_HW-1:0]            hw_tag,
    output logic                           tag_valid
);

    localparam int GROUP_BYTES = 2 * FETCH_HW;

    logic [ADDR_W-1:0]   base;
    logic                vle_eff;
    logic [FETCH_HW-1:0] tag_d;
    logic [FETCH_HW-1:0] tag_q;
    logic                valid_q;

    // A translation miss falls back to the fixed-width compare
    assign vle_eff = fetch_vle & fetch_tlb_hit;
    assign base    = fetch_addr & ~ADDR_W'(GROUP_BYTES - 1);

    for (genvar h = 0; h < FETCH_HW; h++) begin : g_hw
        logic [ADDR_W-1:0]  hw_addr;
        logic [NUM_CMP-1:0] hits;

        assign hw_addr = base + ADDR_W'(2 * h);

        for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
            iac_match #(.ADDR_W(ADDR_W)) u_match (
                .addr     (hw_addr),
                .vle_page (vle_eff),
                .pr       (fetch_pr),
                .is_bit   (fetch_is),
                .ctrl     (ctrl[c]),
                .val_a    (val_a[c]),
                .val_b    (val_b[c]),
                .hit      (hits[c])
            );
        end

        assign tag_d[h] = |hits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= fetch_valid;
            tag_q   <= fetch_valid ? tag_d : '0;
        end
    end

    assign hw_tag    = tag_q;
    assign tag_valid = valid_q;

endmodule

// File: rtl/iac_boundary_fsm.sv
module iac_boundary_fsm
    import iac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bnd_valid,
    input  logic bnd_tag,
    input  logic bnd_long,
    input  logic bnd_blocked,
    input  logic bnd_flush,
    input  logic glob_en,
    input  logic clr_req,
    output logic evt_status,
    output logic dbg_req
);

    bnd_state_e state_q;
    bnd_state_e state_d;
    logic       fire;
    logic       status_q;
    logic       req_q;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (bnd_flush) begin
            state_d = BND_FIRST;
        end else begin
            unique case (state_q)
                BND_FIRST: begin
                    if (bnd_valid && !bnd_blocked) begin
                        fire = bnd_tag;
                        if (bnd_long) state_d = BND_SECOND;
                    end
                end
                BND_SECOND: begin
                    if (bnd_valid) state_d = BND_FIRST;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BND_FIRST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            req_q <= fire && glob_en;
            if (fire)         status_q <= 1'b1;
            else if (clr_req) status_q <= 1'b0;
        end
    end

    assign evt_status = status_q;
    assign dbg_req    = req_q;

endmodule

// File: rtl/iac_unit.sv
module iac_unit
    import iac_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_CMP  = 2,
    parameter int FETCH_HW = 2,
    localparam int CFG_AW  = $clog2(NUM_CMP + 1) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                fetch_valid,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic                fetch_vle,
    input  logic                fetch_tlb_hit,
    input  logic                fetch_pr,
    input  logic                fetch_is,
    output logic [FETCH_HW-1:0] hw_tag,
    output logic                tag_valid,
    input  logic                bnd_valid,
    input  logic                bnd_tag,
    input  logic                bnd_long,
    input  logic                bnd_blocked,
    input  logic                bnd_flush,
    output logic                evt_status,
    output logic                dbg_req
);

    iac_ctrl_t [NUM_CMP-1:0]        ctrl;
    logic [NUM_CMP-1:0][ADDR_W-1:0] val_a;
    logic [NUM_CMP-1:0][ADDR_W-1:0] val_b;
    logic                           glob_en;
    logic                           clr_req;

    iac_cfg_regs #(
        .ADDR_W  (ADDR_W),
        .NUM_CMP (NUM_CMP),
        .CFG_AW  (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .val_a     (val_a),
        .val_b     (val_b),
        .glob_en   (glob_en),
        .clr_req   (clr_req)
    );

    iac_tagger #(
        .ADDR_W   (ADDR_W),
        .NUM_CMP  (NUM_CMP),
        .FETCH_HW (FETCH_HW)
    ) u_tag (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_vle     (fetch_vle),
        .fetch_tlb_hit (fetch_tlb_hit),
        .fetch_pr      (fetch_pr),
        .fetch_is      (fetch_is),
        .ctrl          (ctrl),
        .val_a         (val_a),
        .val_b         (val_b),
        .hw_tag        (hw_tag),
        .tag_valid     (tag_valid)
    );

    iac_boundary_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bnd_valid   (bnd_valid),
        .bnd_tag     (bnd_tag),
        .bnd_long    (bnd_long),
        .bnd_blocked (bnd_blocked),
        .bnd_flush   (bnd_flush),
        .glob_en     (glob_en),
        .clr_req     (clr_req),
        .evt_status  (evt_status),
        .dbg_req     (dbg_req)
    );

endmodule

// File: rtl/iac_unit_chk.sv
module iac_unit_chk
    import iac_pkg::*;
#(
    parameter int FETCH_HW = 2,
    parameter int CFG_AW   = 4,
    parameter int NUM_CMP  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [CFG_AW-1:0]   cfg_addr,
    input logic                cfg_wdata0,
    input logic                fetch_valid,
    input logic [FETCH_HW-1:0] hw_tag,
    input logic                tag_valid,
    input logic                bnd_valid,
    input logic                bnd_blocked,
    input logic                bnd_flush,
    input logic                evt_status,
    input logic                dbg_req,
    input logic                glob_en,
    input bnd_state_e          bnd_state
);

    localparam logic [CFG_AW-1:0] CLR_ADDR = {(CFG_AW-2)'(NUM_CMP), SEL_G_CLR};

    logic clr_write;
    assign clr_write = cfg_we && (cfg_addr == CLR_ADDR) && cfg_wdata0;

    assert_tag_follows_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> tag_valid);

    assert_tag_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_valid |-> (hw_tag == '0));

    assert_tail_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_status && bnd_state == BND_SECOND && bnd_valid) |=> !evt_status);

    assert_flush_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_flush |=> (bnd_state == BND_FIRST));

    assert_blocked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_status && bnd_blocked) |=> !evt_status);

    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_status && !clr_write) |=> evt_status);

    assert_req_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> $past(glob_en));

    assert_req_with_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> evt_status);

endmodule

bind iac_unit iac_unit_chk #(
    .FETCH_HW (FETCH_HW),
    .CFG_AW   (CFG_AW),
    .NUM_CMP  (NUM_CMP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata0  (cfg_wdata[0]),
    .fetch_valid (fetch_valid),
    .hw_tag      (hw_tag),
    .tag_valid   (tag_valid),
    .bnd_valid   (bnd_valid),
    .bnd_blocked (bnd_blocked),
    .bnd_flush   (bnd_flush),
    .evt_status  (evt_status),
    .dbg_req     (dbg_req),
    .glob_en     (u_cfg.glob_en),
    .bnd_state   (u_fsm.state_q)
);

// File: tb/iac_unit_test.sv
`timescale 1ns/1ps
module iac_unit_test;

    localparam int ADDR_W   = 32;
    localparam int NUM_CMP  = 2;
    localparam int FETCH_HW = 2;
    localparam int CFG_AW   = 4;

    localparam logic [3:0] A_S0_CTRL = 4'h0;
    localparam logic [3:0] A_S0_A    = 4'h1;
    localparam logic [3:0] A_S0_B    = 4'h2;
    localparam logic [3:0] A_S1_CTRL = 4'h4;
    localparam logic [3:0] A_S1_A    = 4'h5;
    localparam logic [3:0] A_G_EN    = 4'h8;
    localparam logic [3:0] A_G_CLR   = 4'h9;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_we = 1'b0;
    logic [CFG_AW-1:0]   cfg_addr = '0;
    logic [ADDR_W-1:0]   cfg_wdata = '0;
    logic                fetch_valid = 1'b0;
    logic [ADDR_W-1:0]   fetch_addr = '0;
    logic                fetch_vle = 1'b0;
    logic                fetch_tlb_hit = 1'b1;
    logic                fetch_pr = 1'b0;
    logic                fetch_is = 1'b0;
    logic [FETCH_HW-1:0] hw_tag;
    logic                tag_valid;
    logic                bnd_valid = 1'b0;
    logic                bnd_tag = 1'b0;
    logic                bnd_long = 1'b0;
    logic                bnd_blocked = 1'b0;
    logic                bnd_flush = 1'b0;
    logic                evt_status;
    logic                dbg_req;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    iac_unit #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP), .FETCH_HW(FETCH_HW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_vle     (fetch_vle),
        .fetch_tlb_hit (fetch_tlb_hit),
        .fetch_pr      (fetch_pr),
        .fetch_is      (fetch_is),
        .hw_tag        (hw_tag),
        .tag_valid     (tag_valid),
        .bnd_valid     (bnd_valid),
        .bnd_tag       (bnd_tag),
        .bnd_long      (bnd_long),
        .bnd_blocked   (bnd_blocked),
        .bnd_flush     (bnd_flush),
        .evt_status    (evt_status),
        .dbg_req       (dbg_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup_slot0(input logic [7:0] ctrl, input logic [31:0] a, input logic [31:0] b);
        wr(A_S1_CTRL, 32'h0);
        wr(A_S0_A, a);
        wr(A_S0_B, b);
        wr(A_S0_CTRL, {24'h0, ctrl});
    endtask

    task automatic fetch_chk(input string req, input logic [31:0] addr, input logic vle,
                             input logic tlb, input logic pr, input logic isb,
                             input logic [1:0] exp);
        fetch_valid = 1'b1; fetch_addr = addr; fetch_vle = vle;
        fetch_tlb_hit = tlb; fetch_pr = pr; fetch_is = isb;
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0;
        check(req, {30'h0, hw_tag}, {30'h0, exp});
        check(req, {31'h0, tag_valid}, 32'h1);
    endtask

    task automatic bnd_step(input logic v, input logic t, input logic lg,
                            input logic blk, input logic fl);
        bnd_valid = v; bnd_tag = t; bnd_long = lg; bnd_blocked = blk; bnd_flush = fl;
        @(posedge clk); @(negedge clk);
        bnd_valid = 1'b0; bnd_tag = 1'b0; bnd_long = 1'b0; bnd_blocked = 1'b0; bnd_flush = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 reset tag", {30'h0, hw_tag}, 32'h0);
        check("R12 reset tag_valid", {31'h0, tag_valid}, 32'h0);
        check("R12 reset status", {31'h0, evt_status}, 32'h0);
        check("R12 reset req", {31'h0, dbg_req}, 32'h0);
        fetch_chk("R12 no comparator after reset", 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
        @(negedge clk);
        check("R4 idle tag_valid", {31'h0, tag_valid}, 32'h0);
    endtask

    task automatic t_width;
        setup_slot0(8'h01, 32'h1002, 32'h0);
        fetch_chk("R1 variable page keeps bit1", 32'h1000, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10);
        fetch_chk("R4 R13 other word no hit", 32'h1004, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
        fetch_chk("R2 fixed page drops bit1", 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11);
        fetch_chk("R3 tlb miss uses fixed width", 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11);
        fetch_chk("R4 unaligned fetch address base", 32'h1003, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10);
    endtask

    task automatic t_mask;
        setup_slot0(8'h03, 32'h0000_2000, 32'hFFFF_F000);
        fetch_chk("R5 masked inside", 32'h2ABC, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11);
        fetch_chk("R5 masked outside", 32'h3000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_range;
        setup_slot0(8'h05, 32'h4000, 32'h4008);
        fetch_chk("R6 range inside", 32'h4004, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11);
        fetch_chk("R6 range lower bound", 32'h4000, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11);
        fetch_chk("R6 range upper exclusive", 32'h4008, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
        fetch_chk("R6 range below", 32'h3FFC, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
        wr(A_S0_CTRL, 32'h0D);
        fetch_chk("R6 outside sense hit", 32'h4008, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11);
        fetch_chk("R6 outside sense miss", 32'h4004, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_qual;
        setup_slot0(8'h31, 32'h5000, 32'h0);
        fetch_chk("R7 user-only in user", 32'h5000, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11);
        fetch_chk("R7 user-only in supervisor", 32'h5000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
        wr(A_S0_CTRL, 32'hC1);
        fetch_chk("R7 space one match", 32'h5000, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11);
        fetch_chk("R7 space zero reject", 32'h5000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_disable;
        setup_slot0(8'h00, 32'h5000, 32'h0);
        fetch_chk("R12 disabled comparator", 32'h5000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
        wr(A_S0_CTRL, 32'h07);
        fetch_chk("R12 mode 3 never hits", 32'h5000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
        wr(A_S0_CTRL, 32'h0);
        wr(A_S1_A, 32'h6000);
        wr(A_S1_CTRL, 32'h01);
        fetch_chk("R4 R13 second slot ORed", 32'h6000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11);
        wr(A_S1_CTRL, 32'h0);
    endtask

    task automatic t_boundary;
        wr(A_G_EN, 32'h1);
        wr(A_G_CLR, 32'h1);
        bnd_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        bnd_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 tail half-word ignored", {31'h0, evt_status}, 32'h0);
        check("R8 tail no request", {31'h0, dbg_req}, 32'h0);
        bnd_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 first half-word fires", {31'h0, evt_status}, 32'h1);
        check("R11 request pulse", {31'h0, dbg_req}, 32'h1);
        bnd_step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 pulse one cycle", {31'h0, dbg_req}, 32'h0);
        check("R10 status held", {31'h0, evt_status}, 32'h1);
        wr(A_G_CLR, 32'h1);
        check("R10 cleared", {31'h0, evt_status}, 32'h0);
        bnd_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        bnd_step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        bnd_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 flush realigns to first", {31'h0, evt_status}, 32'h1);
        wr(A_G_CLR, 32'h1);
        bnd_step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        bnd_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 flushed beat discarded", {31'h0, evt_status}, 32'h1);
    endtask

    task automatic t_blocked;
        wr(A_G_CLR, 32'h1);
        bnd_step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R9 blocked no event", {31'h0, evt_status}, 32'h0);
        check("R9 blocked no request", {31'h0, dbg_req}, 32'h0);
        bnd_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 state kept at first", {31'h0, evt_status}, 32'h1);
    endtask

    task automatic t_status;
        wr(A_G_EN, 32'h0);
        wr(A_G_CLR, 32'h1);
        bnd_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R10 recorded while disabled", {31'h0, evt_status}, 32'h1);
        check("R11 no request while disabled", {31'h0, dbg_req}, 32'h0);
        wr(A_G_CLR, 32'h0);
        check("R10 zero write keeps status", {31'h0, evt_status}, 32'h1);
        wr(A_G_CLR, 32'h1);
        check("R10 one write clears", {31'h0, evt_status}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_width();
        t_mask();
        t_range();
        t_qual();
        t_disable();
        t_boundary();
        t_blocked();
        t_status();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule